// File: doc/BRIEF.md
# Single-Shot Transmit Request Manager

This block holds three flags per message buffer: a pending transmit request, a new-data marker and a transmit interrupt pending bit. It picks the buffer the protocol engine should send next and updates the flags from the engine's frame-start, frame-success and frame-failure events. Software sets and clears the flags through per-buffer strobes. It also gives a per-buffer transmit interrupt enable, a mode bit that picks automatic retransmission or single-shot operation, and the controller's initialisation bit.

In retransmission mode a buffer keeps its request until its frame is sent successfully, so a lost arbitration or a bus error leads straight to another attempt. In single-shot mode the start of a frame withdraws every pending request. A failed frame is not retried, and its data stays marked new so that software can see it was never delivered and request it again. The buffer with the lowest index wins when several are pending.

Top module: `txreq_mgr`

## Requirements
- R1: After synchronous reset all request, new-data and interrupt-pending flags are 0, the mode is retransmission (`single_shot_o` = 0) and `req_valid_o` is 0.
- R2: While the initialisation bit is 0 and at least one request flag is set, `req_valid_o` is 1 and `sel_idx_o` is the lowest index whose request flag is set (index 0 has the highest priority).
- R3: While the initialisation bit is 1, `req_valid_o` is 0 and the start, success and failure events change no flag.
- R4: A set strobe for a buffer sets both its request and new-data flags on the next edge. A request clear strobe clears only its request flag, and an interrupt clear strobe clears only its pending flag. A set strobe wins over any clear in the same cycle.
- R5: A mode write (`mode_val_i` = 1 selects single-shot) takes effect only in a cycle where the initialisation bit is 1. A mode write in any other cycle leaves `single_shot_o` unchanged.
- R6: In single-shot mode, an accepted frame start clears the request flag of every buffer and leaves all new-data flags unchanged.
- R7: A success event clears the new-data and request flags of the buffer that was selected at the accepted start, and no other buffer's flags.
- R8: A success event sets that buffer's interrupt-pending flag if and only if its transmit interrupt enable is 1 in the cycle of the success event.
- R9: In single-shot mode, a failure event leaves the buffer's new-data flag set and its request flag clear, and nothing is selected until software sets the request again.
- R10: In retransmission mode, an accepted start and a later failure both leave the request flag set, so the same buffer is selected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_i | input | 1 | Initialisation bit; 1 halts the engine side |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_val_i | input | 1 | Mode value to write, 1 = single-shot |
| req_set_i | input | NBUF | Per-buffer set strobe for request and new-data |
| req_clr_i | input | NBUF | Per-buffer request clear strobe |
| ipnd_clr_i | input | NBUF | Per-buffer interrupt-pending clear strobe |
| txie_i | input | NBUF | Per-buffer transmit interrupt enable |
| eng_start_i | input | 1 | Engine begins a frame from the selected buffer |
| eng_ok_i | input | 1 | Engine finished the current frame successfully |
| eng_fail_i | input | 1 | Engine lost arbitration or saw an error |
| sel_idx_o | output | IDXW | Index of the buffer to send next |
| req_valid_o | output | 1 | A selected buffer is available |
| req_o | output | NBUF | Request flags |
| newdat_o | output | NBUF | New-data flags |
| ipnd_o | output | NBUF | Interrupt-pending flags |
| single_shot_o | output | 1 | Current mode, 1 = single-shot |

## Verification
The assertions assume the engine raises a start only against the buffer currently offered, and raises success or failure only for a frame in flight. The RTL drops a start while a frame is active, and drops success or failure while none is active, so the properties on flag updates only reason about accepted events. The random phase still fires events freely, including during initialisation and while idle, to exercise those drops. The bench's behavioural model applies the same acceptance rule, so every field is compared on every cycle.

// File: rtl/txreq_pkg.sv
`timescale 1ns/1ps
// Shared types for the transmit request manager.
package txreq_pkg;
    typedef enum logic {
        MODE_RETRY  = 1'b0,
        MODE_SINGLE = 1'b1
    } tx_mode_e;

    typedef struct packed {
        logic start;
        logic ok;
        logic fail;
    } eng_evt_t;
endpackage

// File: rtl/txreq_arb.sv
`timescale 1ns/1ps
// Fixed-priority picker: returns the lowest set index of the request vector.
// Assumes: purely combinational; clk/rst_n serve only the guard properties.
module txreq_arb #(
    parameter int NBUF = 32,
    parameter int IDXW = $clog2(NBUF)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NBUF-1:0] req_i,
    output logic [IDXW-1:0] idx_o,
    output logic            any_o
);
    localparam logic [NBUF-1:0] ONE = NBUF'(1);

    // Scan downwards so the lowest set bit is the one that sticks.
    always_comb begin
        idx_o = '0;
        any_o = |req_i;
        for (int i = NBUF - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDXW'(i);
        end
    end

    assert_sel_is_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> req_i[idx_o]);
    assert_sel_lowest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> ((req_i & ((ONE << idx_o) - ONE)) == '0));
endmodule

// File: rtl/txreq_ctrl.sv
`timescale 1ns/1ps
// Mode register and in-flight tracker. Qualifies engine events: a start is
// taken only when idle, not in init and with a request offered; success or
// failure only while a frame is active (success wins if both arrive).
module txreq_ctrl
    import txreq_pkg::*;
#(
    parameter int IDXW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init_i,
    input  logic            mode_wr_i,
    input  logic            mode_val_i,
    input  eng_evt_t        evt_i,
    input  logic            req_any_i,
    input  logic [IDXW-1:0] sel_idx_i,
    output logic            single_o,
    output logic            start_acc_o,
    output logic            ok_acc_o,
    output logic            fail_acc_o,
    output logic [IDXW-1:0] act_idx_o
);
    tx_mode_e mode_q;
    logic     active_q;

    // Accept engine events according to the tracker state.
    always_comb begin
        start_acc_o = evt_i.start & ~init_i & ~active_q & req_any_i;
        ok_acc_o    = evt_i.ok & ~init_i & active_q;
        fail_acc_o  = evt_i.fail & ~evt_i.ok & ~init_i & active_q;
        single_o    = (mode_q == MODE_SINGLE);
    end

    // Mode bit: writable only while init is held.
    always_ff @(posedge clk) begin
        if (!rst_n)                    mode_q <= MODE_RETRY;
        else if (init_i && mode_wr_i)  mode_q <= tx_mode_e'(mode_val_i);
    end

    // Frame-in-flight flag; init aborts any frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                       active_q <= 1'b0;
        else if (init_i)                  active_q <= 1'b0;
        else if (start_acc_o)             active_q <= 1'b1;
        else if (ok_acc_o || fail_acc_o)  active_q <= 1'b0;
    end

    // Remember which buffer the current frame came from.
    always_ff @(posedge clk) begin
        if (!rst_n)           act_idx_o <= '0;
        else if (start_acc_o) act_idx_o <= sel_idx_i;
    end

    assert_mode_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !init_i |=> $stable(mode_q));
    assert_init_aborts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> !active_q);
endmodule

// File: rtl/txreq_flags.sv
`timescale 1ns/1ps
// Per-buffer flag bank: request, new-data and interrupt-pending bits.
// Assumes: start/ok/fail inputs are already qualified by txreq_ctrl and
// act_idx_i names the buffer whose frame is in flight.
module txreq_flags #(
    parameter int NBUF = 32,
    parameter int IDXW = $clog2(NBUF)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init_i,
    input  logic [NBUF-1:0] set_i,
    input  logic [NBUF-1:0] clr_i,
    input  logic [NBUF-1:0] ipclr_i,
    input  logic [NBUF-1:0] txie_i,
    input  logic            single_i,
    input  logic            start_acc_i,
    input  logic            ok_acc_i,
    input  logic            fail_acc_i,
    input  logic [IDXW-1:0] act_idx_i,
    output logic [NBUF-1:0] req_o,
    output logic [NBUF-1:0] nd_o,
    output logic [NBUF-1:0] ip_o
);
    logic flush_all;
    assign flush_all = start_acc_i & single_i;

    for (genvar i = 0; i < NBUF; i++) begin : g_buf
        logic done_here;
        logic fail_here;
        assign done_here = ok_acc_i   && (act_idx_i == IDXW'(i));
        assign fail_here = fail_acc_i && (act_idx_i == IDXW'(i));

        // Request bit: CPU set wins; cleared by CPU, single-shot start or success.
        always_ff @(posedge clk) begin
            if (!rst_n) req_o[i] <= 1'b0;
            else        req_o[i] <= set_i[i] |
                                    (req_o[i] & ~clr_i[i] & ~flush_all & ~done_here);
        end

        // New-data bit: set with the request, cleared only by success.
        always_ff @(posedge clk) begin
            if (!rst_n) nd_o[i] <= 1'b0;
            else        nd_o[i] <= set_i[i] | (nd_o[i] & ~done_here);
        end

        // Interrupt-pending bit: raised on success when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n) ip_o[i] <= 1'b0;
            else        ip_o[i] <= (ip_o[i] & ~ipclr_i[i]) | (done_here & txie_i[i]);
        end

        assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (done_here && !set_i[i]) |=> (!nd_o[i] && !req_o[i]));
        assert_ip_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ip_o[i]) |-> $past(done_here && txie_i[i]));
        assert_fail_keeps_nd_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (fail_here && nd_o[i]) |=> nd_o[i]);
        assert_retry_keeps_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (fail_here && !single_i && req_o[i] && !clr_i[i]) |=> req_o[i]);
    end

    assert_flush_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all && set_i == '0) |=> (req_o == '0));
    assert_init_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (init_i && set_i == '0) |=> $stable(nd_o));
endmodule

// File: rtl/txreq_mgr.sv
`timescale 1ns/1ps
// Transmit request manager top: ties the picker, tracker and flag bank.
// Assumes: the engine samples sel_idx_o in the cycle it raises eng_start_i.
module txreq_mgr
    import txreq_pkg::*;
#(
    parameter int NBUF = 32,
    parameter int IDXW = $clog2(NBUF)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init_i,
    input  logic            mode_wr_i,
    input  logic            mode_val_i,
    input  logic [NBUF-1:0] req_set_i,
    input  logic [NBUF-1:0] req_clr_i,
    input  logic [NBUF-1:0] ipnd_clr_i,
    input  logic [NBUF-1:0] txie_i,
    input  logic            eng_start_i,
    input  logic            eng_ok_i,
    input  logic            eng_fail_i,
    output logic [IDXW-1:0] sel_idx_o,
    output logic            req_valid_o,
    output logic [NBUF-1:0] req_o,
    output logic [NBUF-1:0] newdat_o,
    output logic [NBUF-1:0] ipnd_o,
    output logic            single_shot_o
);
    eng_evt_t        evt;
    logic            any_req;
    logic            start_acc, ok_acc, fail_acc;
    logic [IDXW-1:0] act_idx;

    assign evt         = '{start: eng_start_i, ok: eng_ok_i, fail: eng_fail_i};
    assign req_valid_o = any_req & ~init_i;

    txreq_arb #(.NBUF(NBUF), .IDXW(IDXW)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req_o),
        .idx_o (sel_idx_o),
        .any_o (any_req)
    );

    txreq_ctrl #(.IDXW(IDXW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_i      (init_i),
        .mode_wr_i   (mode_wr_i),
        .mode_val_i  (mode_val_i),
        .evt_i       (evt),
        .req_any_i   (any_req),
        .sel_idx_i   (sel_idx_o),
        .single_o    (single_shot_o),
        .start_acc_o (start_acc),
        .ok_acc_o    (ok_acc),
        .fail_acc_o  (fail_acc),
        .act_idx_o   (act_idx)
    );

    txreq_flags #(.NBUF(NBUF), .IDXW(IDXW)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_i      (init_i),
        .set_i       (req_set_i),
        .clr_i       (req_clr_i),
        .ipclr_i     (ipnd_clr_i),
        .txie_i      (txie_i),
        .single_i    (single_shot_o),
        .start_acc_i (start_acc),
        .ok_acc_i    (ok_acc),
        .fail_acc_i  (fail_acc),
        .act_idx_i   (act_idx),
        .req_o       (req_o),
        .nd_o        (newdat_o),
        .ip_o        (ipnd_o)
    );

    assert_quiet_in_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |-> !req_valid_o);
endmodule

// File: tb/txreq_mgr_tb.sv
`timescale 1ns/1ps
module txreq_mgr_tb;
    localparam int NB = 32;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst_n, init, mode_wr, mode_val;
    logic [NB-1:0] rset, rclr, iclr, txie;
    logic          st, ok, fl;
    logic [IW-1:0] sel;
    logic          vld, single;
    logic [NB-1:0] req, nd, ip;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 0;

    // Reference model state
    logic [NB-1:0] m_req, m_nd, m_ip;
    logic          m_mode, m_act;
    int            m_aidx;

    always #2.5 clk = ~clk;

    txreq_mgr #(.NBUF(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .init_i(init), .mode_wr_i(mode_wr),
        .mode_val_i(mode_val), .req_set_i(rset), .req_clr_i(rclr),
        .ipnd_clr_i(iclr), .txie_i(txie), .eng_start_i(st), .eng_ok_i(ok),
        .eng_fail_i(fl), .sel_idx_o(sel), .req_valid_o(vld), .req_o(req),
        .newdat_o(nd), .ipnd_o(ip), .single_shot_o(single)
    );

    function automatic int lowest(logic [NB-1:0] v);
        for (int i = 0; i < NB; i++) if (v[i]) return i;
        return 0;
    endfunction

    // Behavioural model, advanced on each rising edge.
    always @(posedge clk) begin
        logic [NB-1:0] kill_req, kill_nd, set_ip;
        kill_req = '0; kill_nd = '0; set_ip = '0;
        if (!rst_n) begin
            m_req = '0; m_nd = '0; m_ip = '0; m_mode = 0; m_act = 0; m_aidx = 0;
        end else begin
            if (init) begin
                m_act = 0;
                if (mode_wr) m_mode = mode_val;
            end else if (st && !m_act && m_req != '0) begin
                m_aidx = lowest(m_req);
                m_act  = 1;
                if (m_mode) kill_req = '1;
            end else if (ok && m_act) begin
                kill_req[m_aidx] = 1'b1;
                kill_nd[m_aidx]  = 1'b1;
                set_ip[m_aidx]   = txie[m_aidx];
                m_act = 0;
            end else if (fl && m_act) begin
                m_act = 0;
            end
            m_req = (m_req & ~kill_req & ~rclr) | rset;
            m_nd  = (m_nd & ~kill_nd) | rset;
            m_ip  = (m_ip & ~iclr) | set_ip;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One clock: sample after the edge, compare with the model, drop strobes.
    task automatic tick();
        logic exp_v;
        @(posedge clk);
        #1;
        if (rst_n) begin
            exp_v = (m_req != '0) && !init;
            chk("R4 req flags vs model", req, m_req);
            chk("R7 newdat flags vs model", nd, m_nd);
            chk("R8 ipnd flags vs model", ip, m_ip);
            chk("R5 mode vs model", 32'(single), 32'(m_mode));
            chk("R3 valid vs model", 32'(vld), 32'(exp_v));
            if (exp_v) chk("R2 sel vs model", 32'(sel), 32'(lowest(m_req)));
        end
        rset = '0; rclr = '0; iclr = '0; mode_wr = 0; st = 0; ok = 0; fl = 0;
    endtask

    initial begin
        rst_n = 0; init = 1; mode_wr = 0; mode_val = 0;
        rset = '0; rclr = '0; iclr = '0; txie = '0; st = 0; ok = 0; fl = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        chk("R1 req after reset", req, 0);
        chk("R1 newdat after reset", nd, 0);
        chk("R1 ipnd after reset", ip, 0);
        chk("R1 mode after reset", 32'(single), 0);
        chk("R1 valid after reset", 32'(vld), 0);

        // Requests during init: flags set, nothing offered, start ignored.
        txie = 32'h8;
        rset = 32'h28; tick();
        chk("R4 set strobe req", req, 32'h28);
        chk("R4 set strobe newdat", nd, 32'h28);
        chk("R3 no valid in init", 32'(vld), 0);
        st = 1; tick();
        chk("R3 start ignored in init", req, 32'h28);

        init = 0; tick();
        chk("R2 valid", 32'(vld), 1);
        chk("R2 lowest index wins", 32'(sel), 3);

        // Retransmission mode
        st = 1; tick();
        chk("R10 req kept at start", req, 32'h28);
        fl = 1; tick();
        chk("R10 req kept after fail", req, 32'h28);
        chk("R10 same buffer again", 32'(sel), 3);
        st = 1; tick();
        ok = 1; tick();
        chk("R7 newdat cleared", nd, 32'h20);
        chk("R7 req cleared", req, 32'h20);
        chk("R8 ipnd set with txie", ip, 32'h8);
        chk("R2 next buffer", 32'(sel), 5);
        st = 1; tick();
        ok = 1; tick();
        chk("R8 no ipnd without txie", ip, 32'h8);
        chk("R7 all sent", nd, 0);

        // Mode bit lock
        mode_wr = 1; mode_val = 1; tick();
        chk("R5 write ignored outside init", 32'(single), 0);
        init = 1; mode_wr = 1; mode_val = 1; tick();
        init = 0; tick();
        chk("R5 write taken in init", 32'(single), 1);

        // Single-shot: start flushes all pending requests
        rset = (32'h1 << 7) | (32'h1 << 9) | (32'h1 << 20); tick();
        st = 1; tick();
        chk("R6 all requests cleared", req, 0);
        chk("R6 newdat untouched", nd, 32'h00100280);
        chk("R6 nothing offered", 32'(vld), 0);
        ok = 1; tick();
        chk("R7 only sent buffer newdat", nd, 32'h00100200);
        chk("R8 txie off no ipnd", ip, 32'h8);

        // Single-shot failure: no retry
        rset = 32'h1 << 12; tick();
        st = 1; tick();
        fl = 1; tick();
        chk("R9 req stays clear", req, 0);
        chk("R9 newdat kept", nd, 32'h00101200);
        repeat (3) tick();
        chk("R9 no retry", 32'(vld), 0);
        rset = 32'h1 << 12; tick();
        chk("R9 resend on CPU set", 32'(sel), 12);

        // Events ignored in init in single-shot mode
        init = 1; st = 1; tick();
        chk("R3 flush ignored in init", req, 32'h1000);
        init = 0; tick();

        // Clear strobes
        iclr = 32'h8; tick();
        chk("R4 ipnd clear", ip, 0);
        rclr = 32'h1 << 12; tick();
        chk("R4 req clear", req, 0);
        chk("R4 req clear keeps newdat", nd, 32'h00101200);

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] == 0) init = ~init;
            if (init && r[5:4] == 0) begin mode_wr = 1; mode_val = r[6]; end
            if (r[9:7] == 0) rset = 32'h1 << r[31:27];
            if (r[12:10] == 0) rclr = 32'h1 << r[26:22];
            if (r[14:13] == 0) iclr = $urandom;
            if (r[16:15] == 0) txie = $urandom;
            st = r[17] & r[18];
            ok = r[19] & r[20];
            fl = r[21] & r[20];
            tick();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule